// File: doc/BRIEF.md
# PCI Interrupt Pin Router

This block steers the four level-sensitive PCI interrupt pins (A, B, C, D) onto a 16-line ISA interrupt request vector. Each pin has a 4-bit routing code that names the ISA line it drives. The codes are held in three byte-wide configuration registers. Software writes and reads those registers through a simple byte port. A code of zero leaves a pin unconnected. When several pins select the same line, the line is the OR of those pins.

The ISA vector is purely combinational from the current pin levels and the stored codes. An output therefore follows a pin as it rises and falls. A routing change moves an active interrupt to its new line on the cycle after the write, and leaves nothing on the old line. Codes 2, 8 and 13 are reserved. A pin routed to one of them still drives that line, but a sticky error flag records the event for software.

Top module: `pci_irq_router`

## Requirements
- R1: After reset the three routing registers read 0x00, every ISA output is low and the error flag is low.
- R2: Pin A (pci_pin[0]) is routed by bits [7:4] of the register at address 0x55.
- R3: Pin B (pci_pin[1]) is routed by bits [3:0] of the register at 0x56, and pin C (pci_pin[2]) by bits [7:4] of the same register.
- R4: Pin D (pci_pin[3]) is routed by bits [7:4] of the register at 0x57. Bits [3:0] of 0x57 have no effect on routing.
- R5: A routing code of 0 disables its pin. isa_irq[0] is never driven high.
- R6: Each ISA line n is high exactly when at least one high pin has routing code n. Pins sharing a code are ORed.
- R7: isa_irq follows pin assertion and deassertion in the same cycle, with no register on the path.
- R8: A register write takes effect at the next clock edge. From then on an asserted pin appears only on its new line.
- R9: Codes 2, 8 and 13 still route their pin. route_err is set at the clock edge after any cycle in which a high pin carries one of these codes. A reserved code on a low pin does not set it.
- R10: route_err is sticky. It clears only on reset, or on a write with cfg_wdata[0]=1 to address 0x58. Writing 0 there leaves it set. If the flag sets and clears in the same cycle, the set wins.
- R11: Reads of 0x55 to 0x57 return the whole stored byte, unused nibbles included. Any other address reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pci_pin | input | 4 | PCI interrupt levels, bit 0 = A through bit 3 = D |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register byte address |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Read data for cfg_addr (combinational) |
| isa_irq | output | 16 | ISA interrupt request levels |
| route_err | output | 1 | Sticky reserved-routing flag |

## Verification
The bench targets the nibble that is easy to get wrong. It sets the low nibble of 0x57 while pin D is active; a design that decoded that nibble would light the wrong line. It routes two pins to one line and releases them one at a time. A design that let the last writer win instead of ORing would drop the line early. It also reroutes a pin while it is held high, which catches a registered or latched output that leaves a stale level on the old line. The reserved codes are checked both with the pin low and with the pin high, and again while a clear is written. This catches a flag that fires on the stored code alone, loses its stickiness, or lets the clear win over a new set.

// File: rtl/pci_irq_router.sv
module pci_irq_router #(
  parameter logic [7:0] ROUTE_BASE = 8'h55,
  parameter logic [7:0] CLR_ADDR   = 8'h58
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  pci_pin,
  input  logic        cfg_we,
  input  logic [7:0]  cfg_addr,
  input  logic [7:0]  cfg_wdata,
  output logic [7:0]  cfg_rdata,
  output logic [15:0] isa_irq,
  output logic        route_err
);
  localparam int NREG = 3;
  localparam int NPIN = 4;

  logic [7:0] cfg_reg [NREG];
  logic [3:0] code [NPIN];
  logic       hit;
  logic       clr_req;

  assign code[0] = cfg_reg[0][7:4];
  assign code[1] = cfg_reg[1][3:0];
  assign code[2] = cfg_reg[1][7:4];
  assign code[3] = cfg_reg[2][7:4];

  function automatic logic reserved(input logic [3:0] c);
    return (c == 4'd2) || (c == 4'd8) || (c == 4'd13);
  endfunction

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)
        cfg_reg[g] <= 8'h00;
      else if (cfg_we && cfg_addr == ROUTE_BASE + 8'(g))
        cfg_reg[g] <= cfg_wdata;
    end
  end

  always_comb begin
    isa_irq = '0;
    hit     = 1'b0;
    for (int p = 0; p < NPIN; p++) begin
      if (pci_pin[p] && code[p] != 4'd0) isa_irq[code[p]] = 1'b1;
      if (pci_pin[p] && reserved(code[p])) hit = 1'b1;
    end
  end

  assign clr_req = cfg_we && (cfg_addr == CLR_ADDR) && cfg_wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n)       route_err <= 1'b0;
    else if (hit)     route_err <= 1'b1;
    else if (clr_req) route_err <= 1'b0;
  end

  always_comb begin
    cfg_rdata = 8'h00;
    for (int r = 0; r < NREG; r++)
      if (cfg_addr == ROUTE_BASE + 8'(r)) cfg_rdata = cfg_reg[r];
  end
endmodule

module pci_irq_router_chk #(
  parameter logic [7:0] CLR_ADDR = 8'h58
) (
  input logic        clk,
  input logic        rst_n,
  input logic [3:0]  pci_pin,
  input logic        cfg_we,
  input logic [7:0]  cfg_addr,
  input logic [7:0]  cfg_wdata,
  input logic [15:0] isa_irq,
  input logic        route_err,
  input logic [7:0]  r0,
  input logic [7:0]  r1,
  input logic [7:0]  r2
);
  function automatic logic rsv(input logic [3:0] c);
    return c == 4'd2 || c == 4'd8 || c == 4'd13;
  endfunction

  logic bad;
  assign bad = (pci_pin[0] && rsv(r0[7:4])) || (pci_pin[1] && rsv(r1[3:0])) ||
               (pci_pin[2] && rsv(r1[7:4])) || (pci_pin[3] && rsv(r2[7:4]));

  p_idle_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pci_pin == 4'b0000 |-> isa_irq == 16'h0000);
  p_all_disabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (r0[7:4] == 4'd0 && r1 == 8'h00 && r2[7:4] == 4'd0) |-> isa_irq == 16'h0000);
  p_pin_a_map_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pci_pin == 4'b0001 && r0[7:4] != 4'd0) |-> isa_irq == (16'h0001 << r0[7:4]));
  p_err_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bad |=> route_err);
  p_err_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(route_err) |-> $past(bad));
  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (route_err && !(cfg_we && cfg_addr == CLR_ADDR && cfg_wdata[0])) |=> route_err);
endmodule

bind pci_irq_router pci_irq_router_chk #(.CLR_ADDR(CLR_ADDR)) chk_i (
  .clk(clk), .rst_n(rst_n), .pci_pin(pci_pin), .cfg_we(cfg_we),
  .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .isa_irq(isa_irq),
  .route_err(route_err), .r0(cfg_reg[0]), .r1(cfg_reg[1]), .r2(cfg_reg[2])
);

// File: tb/pci_irq_router_tb.sv
module pci_irq_router_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  pci_pin = '0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic [7:0]  cfg_rdata;
  logic [15:0] isa_irq;
  logic        route_err;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pci_irq_router dut_i (.clk(clk), .rst_n(rst_n), .pci_pin(pci_pin), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .isa_irq(isa_irq), .route_err(route_err));

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk); cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 0; #1;
  endtask

  task automatic pins(logic [3:0] p);
    pci_pin = p; #1;
  endtask

  task automatic rd_chk(string req, logic [7:0] a, logic [7:0] exp);
    cfg_addr = a; #1; chk(req, {8'h0, cfg_rdata}, {8'h0, exp});
  endtask

  task automatic t_reset;
    rd_chk("R1", 8'h55, 8'h00); rd_chk("R1", 8'h56, 8'h00); rd_chk("R1", 8'h57, 8'h00);
    pins(4'hF);
    chk("R1 R5", isa_irq, 16'h0000);
    chk("R1", {15'h0, route_err}, 16'h0000);
    pins(4'h0);
  endtask

  task automatic t_pin_map;
    wr(8'h55, 8'h30); wr(8'h56, 8'h7A); wr(8'h57, 8'hC9);
    pins(4'b0001); chk("R2", isa_irq, 16'h0001 << 3);
    pins(4'b0010); chk("R3 pinB", isa_irq, 16'h0001 << 10);
    pins(4'b0100); chk("R3 pinC", isa_irq, 16'h0001 << 7);
    pins(4'b1000); chk("R4", isa_irq, 16'h0001 << 12);
    pins(4'b1111); chk("R6 all", isa_irq, 16'h1488);
    pins(4'b0000); chk("R7 release", isa_irq, 16'h0000);
  endtask

  task automatic t_disable;
    wr(8'h55, 8'h0F); wr(8'h56, 8'h00); wr(8'h57, 8'h05);
    pins(4'hF); chk("R5 R4", isa_irq, 16'h0000);
    pins(4'h0);
  endtask

  task automatic t_share;
    wr(8'h55, 8'hB0); wr(8'h56, 8'h0B);
    pins(4'b0011); chk("R6 both", isa_irq, 16'h0800);
    pins(4'b0010); chk("R6 B only", isa_irq, 16'h0800);
    pins(4'b0000); chk("R7 both low", isa_irq, 16'h0000);
    pins(4'b0001); chk("R7 A again", isa_irq, 16'h0800);
    pins(4'b0000);
  endtask

  task automatic t_reroute;
    wr(8'h56, 8'h00);
    wr(8'h55, 8'h50); pins(4'b0001);
    chk("R8 before", isa_irq, 16'h0020);
    wr(8'h55, 8'h90);
    chk("R8 after", isa_irq, 16'h0200);
    pins(4'b0000);
  endtask

  task automatic t_reserved;
    logic [3:0] codes [3] = '{4'd2, 4'd8, 4'd13};
    for (int i = 0; i < 3; i++) begin
      wr(8'h58, 8'h01);
      wr(8'h57, {codes[i], 4'h0});
      @(negedge clk); #1;
      chk("R9 idle no flag", {15'h0, route_err}, 16'h0);
      pins(4'b1000);
      chk("R9 still routed", isa_irq, 16'h0001 << codes[i]);
      @(negedge clk); #1;
      chk("R9 flag set", {15'h0, route_err}, 16'h1);
      pins(4'b0000);
      @(negedge clk); #1;
      chk("R10 sticky", {15'h0, route_err}, 16'h1);
    end
    wr(8'h58, 8'h00);
    chk("R10 write 0", {15'h0, route_err}, 16'h1);
    pins(4'b1000); wr(8'h58, 8'h01); pins(4'b0000);
    chk("R10 set wins", {15'h0, route_err}, 16'h1);
    wr(8'h58, 8'h01);
    chk("R10 cleared", {15'h0, route_err}, 16'h0);
    wr(8'h57, 8'h00);
  endtask

  task automatic t_readback;
    wr(8'h55, 8'hA5); wr(8'h56, 8'h3C); wr(8'h57, 8'h7F);
    rd_chk("R11 0x55", 8'h55, 8'hA5);
    rd_chk("R11 0x56", 8'h56, 8'h3C);
    rd_chk("R11 0x57", 8'h57, 8'h7F);
    rd_chk("R11 other", 8'h40, 8'h00);
    rd_chk("R11 clr reg", 8'h58, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1; #1;
    t_reset;
    t_pin_map;
    t_disable;
    t_share;
    t_reroute;
    t_reserved;
    t_readback;
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule